// File: doc/BRIEF.md
# Chain-Addressed I2C Target

An I2C target whose own bus address can be changed at run time. Many identical copies share one SCL/SDA pair and are linked in a chain: each copy's enable output drives the active-low reset input of the next one. After its reset is released, a copy answers only the fixed default address. Because every copy further down the chain is still held in reset, exactly one unconfigured copy answers that address at any time.

The controller writes a new address into the copy's address register, usually with the chain-enable bit set in the same byte. When the STOP that ends the write arrives, the copy moves to its new address and raises its enable output. That releases the next copy, which then answers the default address in turn. The address and the enable bit may also be written in two separate transactions. Clearing the enable bit later pulls the enable output low again. SDA uses open-drain signalling with separate input, output-enable and output lines. SCL is an input only, because the target never stretches the clock.

Top module: `chain_addr_i2c_target`

## Requirements
- R1: While `rst_ni` is low, `chain_en_o` is low and SDA is released. After reset the address register reads {default address 0x40, enable 0}, which is the byte 0x80.
- R2: The target pulls SDA low in the ACK slot of an address byte only when the byte's upper 7 bits equal its current address. On a mismatch it never drives SDA for the rest of the transaction, and any write in that transaction is ignored.
- R3: After a matched write address, the first data byte is the register pointer and the next byte is written to that register. The address register sits at pointer 0x10. Every byte of a matched write is ACKed.
- R4: A new address and enable value written to pointer 0x10 take effect only at the STOP that ends the transaction. A repeated START before that STOP is still matched against the old address.
- R5: A single data byte {new address in bits 7:1, 1 in bit 0} moves the target to the new address and raises `chain_en_o` after STOP. The old address is no longer ACKed.
- R6: Writing the address with bit 0 = 0 and then, at the new address, the same address with bit 0 = 1 gives the same end state as R5.
- R7: Writing bit 0 = 0 at a later time drives `chain_en_o` low after STOP.
- R8: A read (write pointer, repeated START, read address, one byte, NACK) returns the committed register byte at pointer 0x10 and 0x00 at any other pointer. SDA is driven MSB first.
- R9: Writes to any pointer other than 0x10 are ACKed and leave the address register unchanged.
- R10: Pulling `rst_ni` low in the middle of a transaction aborts it. The target then returns to the default address with `chain_en_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset, driven by the previous device's enable output |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_o | output | 1 | Data value driven when enabled (always 0, open drain) |
| sda_oe_o | output | 1 | Pulls SDA low when high |
| chain_en_o | output | 1 | Enable for the next device in the chain (its reset input) |

## Verification
The bench targets the STOP-commit boundary. It issues a repeated START inside an address-changing write. A design that committed early would NACK there, and one that committed late would still answer the old address after the STOP. It also checks that a mismatched address never drives SDA, not even in later byte slots. A design that tracked ACK slots without first matching the address would corrupt the bus for whichever copy is actually addressed. It also covers the two-step enable sequence, writes to an unrelated pointer, and a reset that lands in the middle of a byte. Getting these wrong would, respectively, release the next device too early or never release it, clobber the address register, or leave the target answering a stale address.

// File: rtl/chain_i2c_pkg.sv
package chain_i2c_pkg;
  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } state_t;
endpackage

// File: rtl/chain_i2c_line_sync.sv
module chain_i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_q;
      sda_d  <= sda_q;
    end
  end

  assign scl_q      = scl_ff[STAGES-1];
  assign sda_q      = sda_ff[STAGES-1];
  assign sda_o      = sda_q;
  assign scl_rise_o = scl_q & ~scl_d;
  assign scl_fall_o = ~scl_q & scl_d;
  // SDA edges while SCL stays high mark bus conditions
  assign start_o    = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_o     = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/chain_i2c_engine.sv
module chain_i2c_engine
  import chain_i2c_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [6:0] dev_addr_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] ptr_o,
  output logic       wr_o,
  output logic [7:0] wr_data_o,
  output logic       sda_oe_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_BITS - 1);

  state_t           state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       sh_q, tx_q, ptr_q;
  logic             rw_q, first_q, nack_q;
  logic             byte_done;

  assign byte_done = scl_fall_i && (cnt_q == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      nack_q  <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WR_BYTE: begin
          if (scl_rise_i && cnt_q != FULL) begin
            sh_q  <= {sh_q[6:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
          end
          if (byte_done) begin
            if (state_q == ST_ADDR) begin
              rw_q    <= sh_q[0];
              state_q <= (sh_q[7:1] == dev_addr_i) ? ST_ADDR_ACK : ST_IDLE;
            end else begin
              if (first_q) ptr_q <= sh_q;
              first_q <= 1'b0;
              state_q <= ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall_i) begin
          cnt_q <= '0;
          if (rw_q) begin
            tx_q    <= rd_data_i;
            state_q <= ST_RD_BYTE;
          end else begin
            first_q <= 1'b1;
            state_q <= ST_WR_BYTE;
          end
        end
        ST_WR_ACK: if (scl_fall_i) begin
          cnt_q   <= '0;
          state_q <= ST_WR_BYTE;
        end
        ST_RD_BYTE: if (scl_fall_i) begin
          if (cnt_q == LAST) state_q <= ST_RD_ACK;
          else begin
            tx_q  <= {tx_q[6:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) nack_q <= sda_i;
          if (scl_fall_i) begin
            if (nack_q) state_q <= ST_IDLE;
            else begin
              tx_q    <= rd_data_i;
              cnt_q   <= '0;
              state_q <= ST_RD_BYTE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_o      = (state_q == ST_WR_BYTE) && byte_done && !first_q && !start_i && !stop_i;
  assign wr_data_o = sh_q;
  assign ptr_o     = ptr_q;
  assign sda_oe_o  = (state_q == ST_ADDR_ACK) || (state_q == ST_WR_ACK) ||
                     ((state_q == ST_RD_BYTE) && !tx_q[7]);

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_o); // R2
  AST_ACK_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR_ACK) |-> (sh_q[7:1] == dev_addr_i)); // R2
  AST_BIT_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL); // R3
endmodule

// File: rtl/chain_i2c_addr_reg.sv
module chain_i2c_addr_reg #(
  parameter logic [6:0] DEF_ADDR = 7'h40,
  parameter logic [7:0] REG_PTR  = 8'h10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] ptr_i,
  input  logic [7:0] wr_data_i,
  input  logic       stop_i,
  output logic [7:0] rd_data_o,
  output logic [6:0] addr_o,
  output logic       en_o
);
  logic [7:0] reg_q, pend_q;
  logic       pend_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q    <= {DEF_ADDR, 1'b0};
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (stop_i) begin
      // commit only at STOP so the live transaction keeps its address
      if (pend_v_q) reg_q <= pend_q;
      pend_v_q <= 1'b0;
    end else if (wr_i && ptr_i == REG_PTR) begin
      pend_q   <= wr_data_i;
      pend_v_q <= 1'b1;
    end
  end

  assign rd_data_o = (ptr_i == REG_PTR) ? reg_q : 8'h00;
  assign addr_o    = reg_q[7:1];
  assign en_o      = reg_q[0];

  AST_EN_RISE_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_o) |-> $past(stop_i)); // R5
  AST_ADDR_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(stop_i) |-> $stable(addr_o)); // R4
endmodule

// File: rtl/chain_addr_i2c_target.sv
module chain_addr_i2c_target #(
  parameter logic [6:0] DEF_ADDR    = 7'h40,
  parameter logic [7:0] REG_PTR     = 8'h10,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic sda_oe_o,
  output logic chain_en_o
);
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0] dev_addr;
  logic [7:0] rd_data, ptr, wr_data;
  logic       wr;

  chain_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  chain_i2c_engine u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .dev_addr_i (dev_addr),
    .rd_data_i  (rd_data),
    .ptr_o      (ptr),
    .wr_o       (wr),
    .wr_data_o  (wr_data),
    .sda_oe_o   (sda_oe_o)
  );

  chain_i2c_addr_reg #(.DEF_ADDR(DEF_ADDR), .REG_PTR(REG_PTR)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .ptr_i     (ptr),
    .wr_data_i (wr_data),
    .stop_i    (stop_det),
    .rd_data_o (rd_data),
    .addr_o    (dev_addr),
    .en_o      (chain_en_o)
  );

  assign sda_o = 1'b0;
endmodule

// File: tb/chain_addr_i2c_target_tb.sv
module chain_addr_i2c_target_tb;
  localparam int Q = 8;
  localparam int NV = 17;

  typedef struct packed {
    logic [1:0] op;    // 0 write, 1 read, 2 probe
    logic [6:0] addr;
    logic [7:0] ptr;
    logic [7:0] data;
    logic       ack;
    logic [7:0] rdata;
    logic       en;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'd2, 7'h40, 8'h00, 8'h00, 1'b1, 8'h00, 1'b0, 4'd2},  // R2 default acked
    '{2'd2, 7'h21, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 4'd2},  // R2 other nacked
    '{2'd1, 7'h40, 8'h10, 8'h00, 1'b1, 8'h80, 1'b0, 4'd1},  // R1 reset value
    '{2'd0, 7'h40, 8'h10, 8'h80, 1'b1, 8'h00, 1'b0, 4'd3},  // R3 framing
    '{2'd0, 7'h40, 8'h22, 8'hAA, 1'b1, 8'h00, 1'b0, 4'd9},  // R9 other ptr
    '{2'd1, 7'h40, 8'h10, 8'h00, 1'b1, 8'h80, 1'b0, 4'd9},  // R9 unchanged
    '{2'd1, 7'h40, 8'h22, 8'h00, 1'b1, 8'h00, 1'b0, 4'd8},  // R8 other ptr reads 0
    '{2'd0, 7'h40, 8'h10, 8'h42, 1'b1, 8'h00, 1'b0, 4'd6},  // R6 step 1
    '{2'd2, 7'h40, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 4'd6},  // R6 old gone
    '{2'd2, 7'h21, 8'h00, 8'h00, 1'b1, 8'h00, 1'b0, 4'd6},  // R6 new live
    '{2'd1, 7'h21, 8'h10, 8'h00, 1'b1, 8'h42, 1'b0, 4'd8},  // R8
    '{2'd0, 7'h21, 8'h10, 8'h43, 1'b1, 8'h00, 1'b1, 4'd6},  // R6 step 2
    '{2'd0, 7'h21, 8'h10, 8'h42, 1'b1, 8'h00, 1'b0, 4'd7},  // R7 clear
    '{2'd0, 7'h21, 8'h10, 8'hB5, 1'b1, 8'h00, 1'b1, 4'd5},  // R5 one write
    '{2'd2, 7'h21, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 4'd5},  // R5 old gone
    '{2'd0, 7'h33, 8'h10, 8'h00, 1'b0, 8'h00, 1'b1, 4'd2},  // R2 mismatch write
    '{2'd1, 7'h5A, 8'h10, 8'h00, 1'b1, 8'hB5, 1'b1, 4'd8}   // R8 and R2 unchanged
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, m_scl, m_sda;
  logic sda_o, sda_oe, chain_en;
  logic sda_bus;
  assign sda_bus = m_sda & ~(sda_oe & ~sda_o);

  int checks = 0;
  int errors = 0;
  logic watch = 1'b0;
  int oe_seen = 0;

  always @(posedge clk) if (watch && sda_oe) oe_seen <= oe_seen + 1;

  chain_addr_i2c_target u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_bus),
    .sda_o      (sda_o),
    .sda_oe_o   (sda_oe),
    .chain_en_o (chain_en)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q / 2);
    ack = ~sda_bus;
    tick(Q / 2);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic ack_it, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      m_scl = 1'b1; tick(Q / 2);
      b[i] = sda_bus;
      tick(Q / 2);
      m_scl = 1'b0;
    end
    tick(1);
    m_sda = ~ack_it; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic write_txn(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                           output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte({a, 1'b0}, a0);
    send_byte(p, a1);
    send_byte(d, a2);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic read_txn(input logic [6:0] a, input logic [7:0] p, output logic ok,
                          output logic [7:0] d);
    logic a0, a1, a2;
    bus_start();
    send_byte({a, 1'b0}, a0);
    send_byte(p, a1);
    bus_start();
    send_byte({a, 1'b1}, a2);
    recv_byte(1'b0, d);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic probe(input logic [6:0] a, output logic ok);
    bus_start();
    send_byte({a, 1'b0}, ok);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ok;
    logic [7:0] rd;
    logic [6:0] dummy;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    tick(5);
    check("R1", "enable in reset", {15'd0, chain_en}, 16'd0);
    check("R1", "sda in reset", {15'd0, sda_oe}, 16'd0);
    rst_n = 1'b1;
    tick(5);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      oe_seen = 0;
      watch = ~v.ack;
      rd = 8'h00;
      unique case (v.op)
        2'd0: write_txn(v.addr, v.ptr, v.data, ok);
        2'd1: read_txn(v.addr, v.ptr, ok, rd);
        default: probe(v.addr, ok);
      endcase
      tick(2);
      watch = 1'b0;
      check($sformatf("R%0d", v.req), $sformatf("vec %0d ack", i), {15'd0, ok}, {15'd0, v.ack});
      check($sformatf("R%0d", v.req), $sformatf("vec %0d enable", i), {15'd0, chain_en},
            {15'd0, v.en});
      if (v.op == 2'd1)
        check($sformatf("R%0d", v.req), $sformatf("vec %0d read", i), {8'd0, rd}, {8'd0, v.rdata});
      if (!v.ack)
        check("R2", $sformatf("vec %0d sda driven", i), oe_seen[15:0], 16'd0);
    end

    // R4: repeated START inside an address-changing write still sees 0x5A
    begin
      logic a0, a1, a2, a3;
      bus_start();
      send_byte({7'h5A, 1'b0}, a0);
      send_byte(8'h10, a1);
      send_byte(8'h62, a2);
      bus_start();
      send_byte({7'h5A, 1'b0}, a3);
      check("R4", "old addr before stop", {15'd0, a3}, 16'd1);
      check("R4", "enable before stop", {15'd0, chain_en}, 16'd1);
      bus_stop();
      tick(2);
      check("R4", "enable after stop", {15'd0, chain_en}, 16'd0);
      dummy = 7'h31;
      probe(dummy, ok);
      check("R4", "new addr after stop", {15'd0, ok}, 16'd1);
    end

    // R10: reset lands mid-byte; default address comes back
    write_txn(7'h31, 8'h10, 8'h63, ok);
    tick(2);
    check("R10", "enable before abort", {15'd0, chain_en}, 16'd1);
    bus_start();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_scl = 1'b0; tick(2);
    rst_n = 1'b0;
    tick(3);
    check("R10", "enable in reset", {15'd0, chain_en}, 16'd0);
    check("R10", "sda in reset", {15'd0, sda_oe}, 16'd0);
    m_sda = 1'b1; m_scl = 1'b1; tick(Q);
    rst_n = 1'b1;
    tick(Q);
    probe(7'h31, ok);
    check("R10", "assigned addr gone", {15'd0, ok}, 16'd0);
    read_txn(7'h40, 8'h10, ok, rd);
    check("R10", "default addr back", {15'd0, ok}, 16'd1);
    check("R10", "register back to default", {8'd0, rd}, 16'h0080);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule